// File: doc/BRIEF.md
# Timer-Driven Descriptor Accumulator

The accumulator takes queue polling off the cores. Whenever the tick strobe fires, it walks its enabled channels and pops descriptors from the queues each channel watches. It stores the popped addresses as a list in a list memory and raises that channel's interrupt once the list is complete. A core reads the finished list, recycles the descriptors itself, and pulses the channel's acknowledge line.

The scan discipline is a build-time parameter. In scan-all mode (`MODE = SCAN_ALL`) every channel is visited on every tick, and channel `c` watches exactly one queue, `QBASE + c`. In rotate mode (`MODE = SCAN_ROTATE`) each tick visits only one channel, in round-robin order, and channel `c` watches `QPC` queues, `QBASE + c*QPC` through `QBASE + c*QPC + QPC-1`.

Each channel owns two list pages that it fills in ping-pong fashion. A list is complete when it is full, when a tick's scan ends with the channel's timeout option set and the list non-empty, or when the channel is disabled while its list is non-empty. At completion the block writes a count word and hands the page to the core. A channel whose two pages are both waiting for acknowledge stops popping.

Both data paths use valid/ready.
- **Pop path:** the block holds `pop_valid` and `pop_qid` steady until `pop_ready`. The queue manager returns `pop_desc` in the cycle of the handshake.
- **List-write path:** the block holds `lw_valid`, `lw_addr` and `lw_data` steady until `lw_ready`.

Either side may stall for any number of cycles. A tick that arrives while a scan is running is remembered and served afterwards. Further ticks during the same scan merge with it.

Top module: `desc_accumulator`

## Requirements
- R1: After reset all `irq` bits are low, `pop_valid` and `lw_valid` are low, and every channel is disabled with write page 0.
- R2: In scan-all mode each tick visits channels 0 to NCH-1 in ascending order, and channel c pops only queue QBASE+c.
- R3: In rotate mode each tick visits one channel, starting at channel 0 after reset and advancing by one per tick with wrap. Channel c pops its QPC queues in ascending order, from QBASE+c*QPC upward.
- R4: A disabled channel, or one whose current write page is still unacknowledged, issues no pop.
- R5: List word address is {channel, page, index}, with an index of log2(MAXL+1) bits. Index 0 holds the entry count. Descriptors sit at indices 1 upward in pop order. A popped value of 0 means the queue is empty and is not stored.
- R6: A list closes when its count reaches the channel size; a size field of 0 or above MAXL means MAXL. Popping then continues on the other page within the same scan.
- R7: When a tick's visit to an enabled channel with its timeout option set ends with a non-empty list, that list closes. Without the option a partial list stays open.
- R8: Closing a list sets that page pending, raises `irq` for the channel and switches the write page. `irq` stays high while either page is pending.
- R9: An `irq_ack` pulse releases the oldest pending page of that channel. With both pages pending, one pulse leaves `irq` high and a second clears it.
- R10: Disabling a channel with a non-empty list writes its count word and raises its `irq`. Disabling an empty channel raises nothing.
- R11: `pop_valid` with `pop_qid`, and `lw_valid` with `lw_addr` and `lw_data`, stay stable from assertion until the ready handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Scan timer strobe |
| cfg_we | input | 1 | Channel configuration write |
| cfg_ch | input | clog2(NCH) | Channel being configured |
| cfg_en | input | 1 | Channel enable |
| cfg_size | input | clog2(MAXL+1) | List size in entries |
| cfg_tmo | input | 1 | Close partial list at end of scan |
| pop_valid | output | 1 | Pop request |
| pop_ready | input | 1 | Queue manager accepts the pop |
| pop_qid | output | QW | Queue to pop |
| pop_desc | input | DW | Popped descriptor address, 0 when empty |
| lw_valid | output | 1 | List-memory write request |
| lw_ready | input | 1 | List memory accepts the write |
| lw_addr | output | clog2(NCH)+1+clog2(MAXL+1) | List word address |
| lw_data | output | DW | Descriptor address or count word |
| irq | output | NCH | Per-channel list-ready interrupt |
| irq_ack | input | NCH | Per-channel acknowledge pulse |

## Verification
The embedded assertions check the following on every cycle:
- request stability on both valid/ready paths while ready is low;
- that no pop is issued for a stalled or full list;
- that a stored descriptor always lands on a free page;
- that `irq` follows a close and falls when the last pending page is acknowledged.

Only the bench scenarios can show what the memory holds and in what order:
- the address layout and the count values;
- the visit order of both scan disciplines;
- that timeout and flush closures happen;
- that a size sweep across the full range fills two pages and then holds back exactly the leftover descriptor.

// File: rtl/dacc_pkg.sv
package dacc_pkg;
  typedef enum logic {
    SCAN_ALL    = 1'b0,
    SCAN_ROTATE = 1'b1
  } scan_mode_e;

  typedef enum logic [1:0] {
    WHY_FULL  = 2'd0,
    WHY_TMO   = 2'd1,
    WHY_FLUSH = 2'd2
  } close_why_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_EVAL  = 3'd1,
    ST_POP   = 3'd2,
    ST_DWR   = 3'd3,
    ST_CWR   = 3'd4,
    ST_QDONE = 3'd5,
    ST_CHEND = 3'd6
  } eng_st_e;
endpackage

// File: rtl/dacc_chan.sv
module dacc_chan #(
  parameter int IW   = 3,
  parameter int MAXL = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_en,
  input  logic [IW-1:0] cfg_size,
  input  logic          cfg_tmo,
  input  logic          push,
  input  logic          close,
  input  logic          ack,
  output logic          en,
  output logic          tmo,
  output logic [IW-1:0] cnt,
  output logic          page,
  output logic          stall,
  output logic          full,
  output logic          flush_need,
  output logic          irq
);
  logic [IW-1:0] size_r;
  logic [IW-1:0] size_eff;
  logic [1:0]    pend;
  logic [1:0]    pend_n;
  logic          ackp;
  logic          ack_take;

  // size 0 or beyond the page capacity falls back to the capacity
  always_comb begin
    if (size_r == '0 || int'(size_r) > MAXL) size_eff = IW'(MAXL);
    else                                     size_eff = size_r;
  end

  assign ack_take = ack && pend[ackp];

  always_comb begin
    pend_n = pend;
    if (ack_take) pend_n[ackp] = 1'b0;
    if (close)    pend_n[page] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en     <= 1'b0;
      tmo    <= 1'b0;
      size_r <= '0;
      cnt    <= '0;
      page   <= 1'b0;
      pend   <= 2'b00;
      ackp   <= 1'b0;
    end else begin
      if (cfg_we) begin
        en     <= cfg_en;
        tmo    <= cfg_tmo;
        size_r <= cfg_size;
      end
      if (close)     cnt <= '0;
      else if (push) cnt <= cnt + 1'b1;
      if (close)     page <= ~page;
      if (ack_take)  ackp <= ~ackp;
      pend <= pend_n;
    end
  end

  assign stall      = pend[page];
  assign full       = (cnt >= size_eff);
  assign flush_need = !en && (cnt != '0);
  assign irq        = |pend;

  AST_PUSH_FREE_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!stall && cnt < size_eff)); // R8
  AST_CLOSE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    close |=> irq); // R8
  AST_LAST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !close && $countones(pend) == 1) |=> !irq); // R9
endmodule

// File: rtl/dacc_engine.sv
module dacc_engine
  import dacc_pkg::*;
#(
  parameter scan_mode_e MODE  = SCAN_ALL,
  parameter int         NCH   = 4,
  parameter int         QPC   = 4,
  parameter int         QBASE = 0,
  parameter int         QW    = 8,
  parameter int         DW    = 32,
  parameter int         IW    = 3,
  parameter int         CHW   = 2,
  parameter int         AW    = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic [NCH-1:0]          en_i,
  input  logic [NCH-1:0]          tmo_i,
  input  logic [NCH-1:0]          stall_i,
  input  logic [NCH-1:0]          full_i,
  input  logic [NCH-1:0]          flush_i,
  input  logic [NCH-1:0]          page_i,
  input  logic [NCH-1:0][IW-1:0]  cnt_i,
  output logic                    pop_valid,
  input  logic                    pop_ready,
  output logic [QW-1:0]           pop_qid,
  input  logic [DW-1:0]           pop_desc,
  output logic                    lw_valid,
  input  logic                    lw_ready,
  output logic [AW-1:0]           lw_addr,
  output logic [DW-1:0]           lw_data,
  output logic [NCH-1:0]          push_o,
  output logic [NCH-1:0]          close_o
);
  localparam int  QCW    = (QPC > 1) ? $clog2(QPC) : 1;
  localparam bit  IS_ROT = (MODE == SCAN_ROTATE);

  eng_st_e       st;
  close_why_e    why;
  logic [CHW-1:0] cur_ch;
  logic [CHW-1:0] rot_ptr;
  logic [QCW-1:0] cur_q;
  logic [DW-1:0]  desc_r;
  logic           tick_pend;
  logic           take_tick;

  logic           c_en, c_tmo, c_stall, c_full, c_page;
  logic [IW-1:0]  c_cnt;
  logic           any_flush;
  logic [CHW-1:0] flush_ch;

  assign c_en    = en_i[cur_ch];
  assign c_tmo   = tmo_i[cur_ch];
  assign c_stall = stall_i[cur_ch];
  assign c_full  = full_i[cur_ch];
  assign c_page  = page_i[cur_ch];
  assign c_cnt   = cnt_i[cur_ch];

  // lowest-numbered channel awaiting a flush
  always_comb begin
    any_flush = 1'b0;
    flush_ch  = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (flush_i[i]) begin
        any_flush = 1'b1;
        flush_ch  = CHW'(i);
      end
    end
  end

  generate
    if (IS_ROT) begin : g_qid_rot
      assign pop_qid = QW'(QBASE) + QW'(cur_ch) * QW'(QPC) + QW'(cur_q);
    end else begin : g_qid_all
      assign pop_qid = QW'(QBASE) + QW'(cur_ch);
    end
  endgenerate

  assign take_tick = (st == ST_IDLE) && !any_flush && tick_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      why       <= WHY_FULL;
      cur_ch    <= '0;
      rot_ptr   <= '0;
      cur_q     <= '0;
      desc_r    <= '0;
      tick_pend <= 1'b0;
    end else begin
      tick_pend <= tick || (tick_pend && !take_tick);
      unique case (st)
        ST_IDLE: begin
          if (any_flush) begin
            cur_ch <= flush_ch;
            why    <= WHY_FLUSH;
            st     <= ST_CWR;
          end else if (tick_pend) begin
            cur_q <= '0;
            if (IS_ROT) begin
              cur_ch  <= rot_ptr;
              rot_ptr <= (rot_ptr == CHW'(NCH - 1)) ? '0 : rot_ptr + 1'b1;
            end else begin
              cur_ch <= '0;
            end
            st <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          if (!c_en || c_stall) st <= ST_QDONE;
          else if (c_full) begin
            why <= WHY_FULL;
            st  <= ST_CWR;
          end else st <= ST_POP;
        end
        ST_POP: begin
          if (pop_ready) begin
            if (pop_desc == '0) st <= ST_QDONE;
            else begin
              desc_r <= pop_desc;
              st     <= ST_DWR;
            end
          end
        end
        ST_DWR: begin
          if (lw_ready) st <= ST_EVAL;
        end
        ST_CWR: begin
          if (lw_ready) begin
            unique case (why)
              WHY_FULL: st <= ST_EVAL;
              WHY_TMO:  st <= ST_CHEND;
              default:  st <= ST_IDLE;
            endcase
          end
        end
        ST_QDONE: begin
          if (IS_ROT && cur_q != QCW'(QPC - 1)) begin
            cur_q <= cur_q + 1'b1;
            st    <= ST_EVAL;
          end else st <= ST_CHEND;
        end
        ST_CHEND: begin
          if (c_en && c_tmo && c_cnt != '0) begin
            why <= WHY_TMO;
            st  <= ST_CWR;
          end else if (!IS_ROT && cur_ch != CHW'(NCH - 1)) begin
            cur_ch <= cur_ch + 1'b1;
            cur_q  <= '0;
            st     <= ST_EVAL;
          end else st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  logic [IW-1:0] wr_idx;
  assign wr_idx    = (st == ST_DWR) ? c_cnt + 1'b1 : '0;
  assign pop_valid = (st == ST_POP);
  assign lw_valid  = (st == ST_DWR) || (st == ST_CWR);
  assign lw_addr   = {cur_ch, c_page, wr_idx};
  assign lw_data   = (st == ST_DWR) ? desc_r : DW'(c_cnt);

  always_comb begin
    push_o  = '0;
    close_o = '0;
    if (st == ST_DWR && lw_ready) push_o[cur_ch]  = 1'b1;
    if (st == ST_CWR && lw_ready) close_o[cur_ch] = 1'b1;
  end

  AST_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_valid && !pop_ready) |=> (pop_valid && $stable(pop_qid))); // R11
  AST_LW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (lw_valid && !lw_ready) |=> (lw_valid && $stable(lw_addr) && $stable(lw_data))); // R11
  AST_NO_POP_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid |-> (!c_stall && !c_full)); // R4
  AST_ONE_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(close_o | push_o)); // R5
endmodule

// File: rtl/desc_accumulator.sv
module desc_accumulator
  import dacc_pkg::*;
#(
  parameter scan_mode_e MODE  = SCAN_ALL,
  parameter int         NCH   = 4,
  parameter int         QPC   = 4,
  parameter int         QBASE = 0,
  parameter int         QW    = 8,
  parameter int         DW    = 32,
  parameter int         MAXL  = 7,
  localparam int        CHW   = $clog2(NCH),
  localparam int        IW    = $clog2(MAXL + 1),
  localparam int        AW    = CHW + 1 + IW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           cfg_we,
  input  logic [CHW-1:0] cfg_ch,
  input  logic           cfg_en,
  input  logic [IW-1:0]  cfg_size,
  input  logic           cfg_tmo,
  output logic           pop_valid,
  input  logic           pop_ready,
  output logic [QW-1:0]  pop_qid,
  input  logic [DW-1:0]  pop_desc,
  output logic           lw_valid,
  input  logic           lw_ready,
  output logic [AW-1:0]  lw_addr,
  output logic [DW-1:0]  lw_data,
  output logic [NCH-1:0] irq,
  input  logic [NCH-1:0] irq_ack
);
  logic [NCH-1:0]         en, tmo, stall, full, flush, page, push, close;
  logic [NCH-1:0][IW-1:0] cnt;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      dacc_chan #(.IW(IW), .MAXL(MAXL)) u_chan (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we && cfg_ch == CHW'(c)),
        .cfg_en     (cfg_en),
        .cfg_size   (cfg_size),
        .cfg_tmo    (cfg_tmo),
        .push       (push[c]),
        .close      (close[c]),
        .ack        (irq_ack[c]),
        .en         (en[c]),
        .tmo        (tmo[c]),
        .cnt        (cnt[c]),
        .page       (page[c]),
        .stall      (stall[c]),
        .full       (full[c]),
        .flush_need (flush[c]),
        .irq        (irq[c])
      );
    end
  endgenerate

  dacc_engine #(
    .MODE(MODE), .NCH(NCH), .QPC(QPC), .QBASE(QBASE), .QW(QW),
    .DW(DW), .IW(IW), .CHW(CHW), .AW(AW)
  ) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .en_i      (en),
    .tmo_i     (tmo),
    .stall_i   (stall),
    .full_i    (full),
    .flush_i   (flush),
    .page_i    (page),
    .cnt_i     (cnt),
    .pop_valid (pop_valid),
    .pop_ready (pop_ready),
    .pop_qid   (pop_qid),
    .pop_desc  (pop_desc),
    .lw_valid  (lw_valid),
    .lw_ready  (lw_ready),
    .lw_addr   (lw_addr),
    .lw_data   (lw_data),
    .push_o    (push),
    .close_o   (close)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    $rose(rst_n) |-> (irq == '0 && !pop_valid && !lw_valid)); // R1
endmodule

// File: tb/test_desc_accumulator.sv
module dacc_qm_model #(
  parameter int NQ = 16,
  parameter int QW = 8,
  parameter int DW = 32,
  parameter int AW = 6,
  parameter int PH = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop_valid,
  input  logic [QW-1:0] pop_qid,
  output logic          pop_ready,
  output logic [DW-1:0] pop_desc,
  input  logic          lw_valid,
  input  logic [AW-1:0] lw_addr,
  input  logic [DW-1:0] lw_data,
  output logic          lw_ready
);
  int          loaded [NQ] = '{default: 0};
  int          served [NQ];
  logic [DW-1:0] mem [2**AW];
  int unsigned cyc;

  function automatic logic [DW-1:0] mk(int q, int s);
    return DW'(32'hA000_0000 | (q << 12) | s);
  endfunction

  function automatic int avail(int q);
    return loaded[q] - served[q];
  endfunction

  task automatic load(int q, int n);
    loaded[q] = loaded[q] + n;
  endtask

  assign pop_ready = ((cyc + PH) % 3) != 1;
  assign lw_ready  = ((cyc + PH) % 4) != 2;

  always_comb begin
    pop_desc = '0;
    if (int'(pop_qid) < NQ && avail(int'(pop_qid)) > 0)
      pop_desc = mk(int'(pop_qid), served[int'(pop_qid)] + 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc <= 0;
      for (int i = 0; i < NQ; i++) served[i] <= 0;
    end else begin
      cyc <= cyc + 1;
      if (pop_valid && pop_ready && int'(pop_qid) < NQ && avail(int'(pop_qid)) > 0)
        served[int'(pop_qid)] <= served[int'(pop_qid)] + 1;
      if (lw_valid && lw_ready) mem[lw_addr] <= lw_data;
    end
  end
endmodule

module test_desc_accumulator;
  import dacc_pkg::*;
  localparam int NCH = 4, QPC = 4, QW = 8, DW = 32, MAXL = 7;
  localparam int CHW = 2, IW = 3, AW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  // scan-all instance signals
  logic h_tick = 0, h_we = 0, h_en = 0, h_tmo = 0;
  logic [CHW-1:0] h_ch = '0;
  logic [IW-1:0]  h_size = '0;
  logic [NCH-1:0] h_ack = '0;
  logic h_pv, h_pr, h_lv, h_lr;
  logic [QW-1:0] h_qid;
  logic [DW-1:0] h_desc, h_ldata;
  logic [AW-1:0] h_laddr;
  logic [NCH-1:0] h_irq;

  // rotate instance signals
  logic l_tick = 0, l_we = 0, l_en = 0, l_tmo = 0;
  logic [CHW-1:0] l_ch = '0;
  logic [IW-1:0]  l_size = '0;
  logic [NCH-1:0] l_ack = '0;
  logic l_pv, l_pr, l_lv, l_lr;
  logic [QW-1:0] l_qid;
  logic [DW-1:0] l_desc, l_ldata;
  logic [AW-1:0] l_laddr;
  logic [NCH-1:0] l_irq;

  desc_accumulator #(.MODE(SCAN_ALL), .NCH(NCH), .QPC(QPC), .QBASE(0),
                     .QW(QW), .DW(DW), .MAXL(MAXL)) i_desc_accumulator (
    .clk(clk), .rst_n(rst_n), .tick(h_tick), .cfg_we(h_we), .cfg_ch(h_ch),
    .cfg_en(h_en), .cfg_size(h_size), .cfg_tmo(h_tmo),
    .pop_valid(h_pv), .pop_ready(h_pr), .pop_qid(h_qid), .pop_desc(h_desc),
    .lw_valid(h_lv), .lw_ready(h_lr), .lw_addr(h_laddr), .lw_data(h_ldata),
    .irq(h_irq), .irq_ack(h_ack));

  desc_accumulator #(.MODE(SCAN_ROTATE), .NCH(NCH), .QPC(QPC), .QBASE(0),
                     .QW(QW), .DW(DW), .MAXL(MAXL)) i_desc_accumulator_lp (
    .clk(clk), .rst_n(rst_n), .tick(l_tick), .cfg_we(l_we), .cfg_ch(l_ch),
    .cfg_en(l_en), .cfg_size(l_size), .cfg_tmo(l_tmo),
    .pop_valid(l_pv), .pop_ready(l_pr), .pop_qid(l_qid), .pop_desc(l_desc),
    .lw_valid(l_lv), .lw_ready(l_lr), .lw_addr(l_laddr), .lw_data(l_ldata),
    .irq(l_irq), .irq_ack(l_ack));

  dacc_qm_model #(.NQ(NCH), .QW(QW), .DW(DW), .AW(AW), .PH(0)) e_hp (
    .clk(clk), .rst_n(rst_n), .pop_valid(h_pv), .pop_qid(h_qid), .pop_ready(h_pr),
    .pop_desc(h_desc), .lw_valid(h_lv), .lw_addr(h_laddr), .lw_data(h_ldata),
    .lw_ready(h_lr));

  dacc_qm_model #(.NQ(NCH*QPC), .QW(QW), .DW(DW), .AW(AW), .PH(1)) e_lp (
    .clk(clk), .rst_n(rst_n), .pop_valid(l_pv), .pop_qid(l_qid), .pop_ready(l_pr),
    .pop_desc(l_desc), .lw_valid(l_lv), .lw_addr(l_laddr), .lw_data(l_ldata),
    .lw_ready(l_lr));

  function automatic logic [31:0] dsc(int q, int s);
    return 32'hA000_0000 | (q << 12) | s;
  endfunction

  function automatic int wa(int ch, int pg, int idx);
    return ch * 2 * (MAXL + 1) + pg * (MAXL + 1) + idx;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic h_cfg(int ch, bit en, int size, bit tmo);
    @(negedge clk);
    h_we = 1; h_ch = CHW'(ch); h_en = en; h_size = IW'(size); h_tmo = tmo;
    @(negedge clk);
    h_we = 0;
  endtask

  task automatic l_cfg(int ch, bit en, int size, bit tmo);
    @(negedge clk);
    l_we = 1; l_ch = CHW'(ch); l_en = en; l_size = IW'(size); l_tmo = tmo;
    @(negedge clk);
    l_we = 0;
  endtask

  task automatic h_pulse_tick();
    @(negedge clk); h_tick = 1; @(negedge clk); h_tick = 0;
    wait_cyc(400);
  endtask

  task automatic l_pulse_tick();
    @(negedge clk); l_tick = 1; @(negedge clk); l_tick = 0;
    wait_cyc(300);
  endtask

  task automatic h_do_ack(int ch);
    @(negedge clk); h_ack[ch] = 1; @(negedge clk); h_ack[ch] = 0;
    wait_cyc(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    int p;
    int sq0;
    wait_cyc(5);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state on both variants
    chk("R1 irq", 32'(h_irq), 0);
    chk("R1 pop_valid", 32'(h_pv), 0);
    chk("R1 lw_valid", 32'(h_lv), 0);
    chk("R1 lp irq", 32'(l_irq), 0);
    h_pulse_tick();
    chk("R1 disabled at reset, no pops", 32'(e_hp.served[0]), 0);

    // ---------- scan-all scenario ----------
    h_cfg(0, 1, 4, 0);
    h_cfg(1, 1, 3, 1);
    h_cfg(2, 0, 5, 1);
    h_cfg(3, 1, 7, 0);
    e_hp.load(0, 4); e_hp.load(1, 2); e_hp.load(2, 5); e_hp.load(3, 3);
    h_pulse_tick();
    chk("R6 ch0 full irq", 32'(h_irq[0]), 1);
    chk("R5 ch0 count word", e_hp.mem[wa(0, 0, 0)], 4);
    for (int k = 1; k <= 4; k++) chk("R2 R5 ch0 desc", e_hp.mem[wa(0, 0, k)], dsc(0, k));
    chk("R7 ch1 timeout irq", 32'(h_irq[1]), 1);
    chk("R7 ch1 count word", e_hp.mem[wa(1, 0, 0)], 2);
    chk("R2 ch1 desc 1", e_hp.mem[wa(1, 0, 1)], dsc(1, 1));
    chk("R2 ch1 desc 2", e_hp.mem[wa(1, 0, 2)], dsc(1, 2));
    chk("R4 disabled ch2 untouched", 32'(e_hp.avail(2)), 5);
    chk("R4 disabled ch2 no irq", 32'(h_irq[2]), 0);
    chk("R7 ch3 partial stays open", 32'(h_irq[3]), 0);
    chk("R2 ch3 popped all", 32'(e_hp.avail(3)), 0);
    h_do_ack(0);
    h_do_ack(1);
    chk("R9 acks clear irq", 32'(h_irq), 0);
    h_cfg(3, 0, 7, 0);
    wait_cyc(40);
    chk("R10 flush irq", 32'(h_irq[3]), 1);
    chk("R10 flush count", e_hp.mem[wa(3, 0, 0)], 3);
    chk("R10 flush desc 3", e_hp.mem[wa(3, 0, 3)], dsc(3, 3));
    h_do_ack(3);
    h_cfg(1, 0, 3, 1);
    wait_cyc(40);
    chk("R10 empty disable no irq", 32'(h_irq[1]), 0);

    // ---------- size sweep on ch0 ----------
    p = 1;
    sq0 = 4;
    for (int s = 1; s <= MAXL; s++) begin
      h_cfg(0, 1, s, 0);
      e_hp.load(0, 2 * s + 1);
      h_pulse_tick();
      chk($sformatf("R8 size%0d irq", s), 32'(h_irq[0]), 1);
      chk($sformatf("R6 size%0d first count", s), e_hp.mem[wa(0, p, 0)], s);
      chk($sformatf("R6 size%0d second count", s), e_hp.mem[wa(0, 1 - p, 0)], s);
      for (int k = 1; k <= s; k++) begin
        chk("R5 first page desc", e_hp.mem[wa(0, p, k)], dsc(0, sq0 + k));
        chk("R6 second page desc", e_hp.mem[wa(0, 1 - p, k)], dsc(0, sq0 + s + k));
      end
      chk($sformatf("R8 size%0d stalled leftover", s), 32'(e_hp.avail(0)), 1);
      h_do_ack(0);
      chk("R9 one ack keeps irq", 32'(h_irq[0]), 1);
      h_do_ack(0);
      chk("R9 second ack clears irq", 32'(h_irq[0]), 0);
      h_pulse_tick();
      chk("R4 released page pops leftover", 32'(e_hp.avail(0)), 0);
      chk("R6 single-entry list closes", 32'(h_irq[0]), (s == 1) ? 1 : 0);
      h_cfg(0, 0, s, 0);
      wait_cyc(40);
      chk("R10 third list irq", 32'(h_irq[0]), 1);
      chk("R10 third list count", e_hp.mem[wa(0, p, 0)], 1);
      chk("R10 third list desc", e_hp.mem[wa(0, p, 1)], dsc(0, sq0 + 2 * s + 1));
      h_do_ack(0);
      chk("R9 ack after third list", 32'(h_irq[0]), 0);
      sq0 = sq0 + 2 * s + 1;
      p = 1 - p;
    end
    h_cfg(0, 1, 0, 1);
    e_hp.load(0, 9);
    h_pulse_tick();
    chk("R6 size 0 means MAXL", e_hp.mem[wa(0, p, 0)], MAXL);
    chk("R6 size 0 rest on other page", e_hp.mem[wa(0, 1 - p, 0)], 2);

    // ---------- rotate scenario ----------
    for (int c = 0; c < NCH; c++) l_cfg(c, 1, 7, 1);
    e_lp.load(1, 1); e_lp.load(4, 1); e_lp.load(7, 2);
    l_pulse_tick();
    chk("R3 tick1 only ch0 irq", 32'(l_irq), 32'b0001);
    chk("R3 ch0 count", e_lp.mem[wa(0, 0, 0)], 1);
    chk("R3 ch0 desc from queue 1", e_lp.mem[wa(0, 0, 1)], dsc(1, 1));
    chk("R3 ch1 not visited q4", 32'(e_lp.avail(4)), 1);
    chk("R3 ch1 not visited q7", 32'(e_lp.avail(7)), 2);
    l_pulse_tick();
    chk("R3 tick2 ch1 irq", 32'(l_irq), 32'b0011);
    chk("R3 ch1 count", e_lp.mem[wa(1, 0, 0)], 3);
    chk("R3 ch1 first q4", e_lp.mem[wa(1, 0, 1)], dsc(4, 1));
    chk("R3 ch1 then q7 a", e_lp.mem[wa(1, 0, 2)], dsc(7, 1));
    chk("R3 ch1 then q7 b", e_lp.mem[wa(1, 0, 3)], dsc(7, 2));
    l_pulse_tick();
    l_pulse_tick();
    chk("R3 ch2 ch3 empty no irq", 32'(l_irq), 32'b0011);
    e_lp.load(0, 2);
    l_pulse_tick();
    chk("R3 wrap to ch0 page1 count", e_lp.mem[wa(0, 1, 0)], 2);
    chk("R8 wrap desc a", e_lp.mem[wa(0, 1, 1)], dsc(0, 1));
    chk("R8 wrap desc b", e_lp.mem[wa(0, 1, 2)], dsc(0, 2));
    chk("R8 irq held", 32'(l_irq), 32'b0011);

    summary();
    $finish;
  end
endmodule